// File: doc/BRIEF.md
# Translation Context Register Bank

This block holds the software-visible state of up to eight address-translation contexts. Each context has its own 64-byte window in a small register space: a control word, translation-control, bus-control, two 64-bit table-base pairs, two attribute words, a fault status word and a fault address word. A translation engine beside it reads the configuration, reports faults into it and completes TLB invalidates that software starts here.

A fault event names a context and carries flag bits, an error code, a walk level and the faulting 32-bit address. The first fault is latched and later ones are dropped until software clears the status. Software clears the status by writing to it, and that write also wipes the captured address, so the address has to be read first. A single interrupt line is asserted while any context with interrupts enabled holds a pending error. Setting the flush bit in a context's control word raises that context's flush request to the engine. The bit reads back as 1 until the engine returns a done pulse.

Top module: `xctx_bank`

## Requirements
- R1: After reset every register of every context reads 0, `irq` is 0 and `flush_req` is all zero.
- R2: Context n occupies byte addresses n*0x40 to n*0x40+0x3F. Word offsets are: control 0x00, translation control 0x08, bus control 0x0C, table base 0 low/high 0x10/0x14, table base 1 low/high 0x18/0x1C, status 0x20, attributes 0x28/0x2C, fault address 0x30. A read returns its data on `bus_rdata` at the clock edge that samples `bus_rd`. A write to one context leaves all other contexts unchanged.
- R3: In the control word only these bits are stored: bit0 enable, bit1 flush, bit2 interrupt enable, bit3 remap enable, bits 5:4 remap table select, bit16 access-flag enable, bit17 remap. This is mask 0x0003_003F, and all other bits read 0.
- R4: A control write with bits 0 and 1 both set makes bit 1 read 1 and drives `flush_req[n]` high. Both stay that way until a `flush_done[n]` pulse is sampled. At that edge bit 1 clears and `flush_req[n]` falls.
- R5: A control write with bit 1 set and bit 0 clear completes the flush at once. Bit 1 reads 0 and `flush_req[n]` stays low.
- R6: A fault event (`flt_valid`, `flt_ctx`) on a context with no pending error is latched at that edge. The status gets `flt_flags[0..3]` at bits 0 (translation), 1 (page), 2 (walk abort) and 4 (multiple hit), `flt_code` at bits 10:8 and `flt_level` at bits 13:12. The fault address word gets `flt_addr`.
- R7: While any of status bits 0, 1, 2 or 4 is set, further fault events on that context change neither status nor fault address.
- R8: Any write to the status word sets both the status and the fault address to 0, whatever the written data.
- R9: `irq` is registered: one cycle after some context has control bit2 set and any of status bits 0, 1, 2, 4 set, it is 1. Otherwise it is 0 one cycle later.
- R10: Offsets with no register (0x04, 0x24, 0x34 to 0x3C) read 0 and writes there are ignored. The fault address word is read-only.
- R11: Translation control, table bases and attributes store all 32 bits. Bus control stores only bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| flt_valid | input | 1 | Fault event strobe |
| flt_ctx | input | CTX_W | Context of the fault |
| flt_flags | input | 4 | {multi-hit, walk abort, page, translation} |
| flt_code | input | 3 | Error code |
| flt_level | input | 2 | Walk level of the error |
| flt_addr | input | 32 | Faulting address |
| flush_done | input | N_CTX | Per-context invalidate-complete pulse |
| flush_req | output | N_CTX | Per-context invalidate request |
| irq | output | 1 | Combined fault interrupt |

## Verification
A stuck flush bit shows up on the next read of the control word and at once on `flush_req`. A flush bit that clears too early shows as `flush_req` falling before the done pulse. A capture gate that is wrong in either direction shows on the first read of the status or fault address after a second fault. A missed clear shows there after the status write. Wrong interrupt gating shows on `irq` one cycle after the status or control change. Decode errors show as data read back from the wrong context or from an empty offset on the next read.

// File: rtl/xctx_pkg.sv
package xctx_pkg;
  localparam int DW = 32;
  // word index = byte offset / 4
  localparam logic [3:0] W_CTRL  = 4'h0;
  localparam logic [3:0] W_XLAT  = 4'h2;
  localparam logic [3:0] W_BUS   = 4'h3;
  localparam logic [3:0] W_TB0L  = 4'h4;
  localparam logic [3:0] W_TB0H  = 4'h5;
  localparam logic [3:0] W_TB1L  = 4'h6;
  localparam logic [3:0] W_TB1H  = 4'h7;
  localparam logic [3:0] W_STAT  = 4'h8;
  localparam logic [3:0] W_ATTR0 = 4'hA;
  localparam logic [3:0] W_ATTR1 = 4'hB;
  localparam logic [3:0] W_FADDR = 4'hC;
  localparam logic [DW-1:0] CTRL_MASK = 32'h0003_003F;
  localparam int CFG_N = 7;

  typedef struct packed {
    logic [3:0]    flags;
    logic [2:0]    code;
    logic [1:0]    level;
    logic [DW-1:0] addr;
  } fault_t;

  // {valid, slot} of a full-width configuration word
  function automatic logic [3:0] cfg_slot(input logic [3:0] w);
    case (w)
      W_XLAT:  return 4'h8;
      W_TB0L:  return 4'h9;
      W_TB0H:  return 4'hA;
      W_TB1L:  return 4'hB;
      W_TB1H:  return 4'hC;
      W_ATTR0: return 4'hD;
      W_ATTR1: return 4'hE;
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic word_mapped(input logic [3:0] w);
    return cfg_slot(w)[3] || w == W_CTRL || w == W_BUS ||
           w == W_STAT || w == W_FADDR;
  endfunction
endpackage

// File: rtl/xctx_slot.sv
module xctx_slot
  import xctx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [3:0]    wr_word,
  input  logic [DW-1:0] wr_data,
  input  logic [3:0]    rd_word,
  output logic [DW-1:0] rd_data,
  input  logic          flt_hit,
  input  fault_t        flt,
  input  logic          flush_done,
  output logic          flush_req,
  output logic          irq_src
);
  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] cfg_q [CFG_N];
  logic [2:0]    bus_q;
  logic [13:0]   stat_q;
  logic [DW-1:0] faddr_q;
  logic          pending, ctrl_wr, st_wr;
  logic [3:0]    wsel, rsel;

  assign pending = stat_q[4] | stat_q[2] | stat_q[1] | stat_q[0];
  assign ctrl_wr = wr_en && wr_word == W_CTRL;
  assign st_wr   = wr_en && wr_word == W_STAT;
  assign wsel    = cfg_slot(wr_word);
  assign rsel    = cfg_slot(rd_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      bus_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q    <= wr_data & CTRL_MASK;
        // a flush on a disabled context finishes on the spot
        ctrl_q[1] <= wr_data[1] & wr_data[0];
      end else if (flush_done) begin
        ctrl_q[1] <= 1'b0;
      end
      if (wr_en && wr_word == W_BUS) bus_q <= wr_data[2:0];
    end
  end

  generate
    for (genvar c = 0; c < CFG_N; c++) begin : g_cfg
      always_ff @(posedge clk) begin
        if (rst) cfg_q[c] <= '0;
        else if (wr_en && wsel == {1'b1, 3'(c)}) cfg_q[c] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      faddr_q <= '0;
    end else if (flt_hit && (!pending || st_wr)) begin
      stat_q  <= {flt.level, 1'b0, flt.code, 3'b0, flt.flags[3], 1'b0,
                  flt.flags[2:0]};
      faddr_q <= flt.addr;
    end else if (st_wr) begin
      stat_q  <= '0;
      faddr_q <= '0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rsel[3]) rd_data = cfg_q[rsel[2:0]];
    else begin
      case (rd_word)
        W_CTRL:  rd_data = ctrl_q;
        W_BUS:   rd_data = {29'b0, bus_q};
        W_STAT:  rd_data = {18'b0, stat_q};
        W_FADDR: rd_data = faddr_q;
        default: rd_data = '0;
      endcase
    end
  end

  assign flush_req = ctrl_q[1];
  assign irq_src   = ctrl_q[2] & pending;

  p_flush_hold_r4: assert property (@(posedge clk) disable iff (rst)
    flush_req && !ctrl_wr && !flush_done |=> flush_req);
  p_flush_done_r4: assert property (@(posedge clk) disable iff (rst)
    flush_done && !ctrl_wr |=> !flush_req);
  p_flush_off_r5: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && !wr_data[0] |=> !flush_req);
  p_capture_r6: assert property (@(posedge clk) disable iff (rst)
    flt_hit && !pending |=> faddr_q == $past(flt.addr));
  p_fault_hold_r7: assert property (@(posedge clk) disable iff (rst)
    pending && !st_wr |=> $stable(faddr_q) && $stable(stat_q));
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    st_wr && !flt_hit |=> stat_q == '0 && faddr_q == '0);
endmodule

// File: rtl/xctx_irq.sv
module xctx_irq #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |src;
  end

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    src == '0 |=> !irq);
  p_irq_raise_r9: assert property (@(posedge clk) disable iff (rst)
    src != '0 |=> irq);
endmodule

// File: rtl/xctx_bank.sv
module xctx_bank
  import xctx_pkg::*;
#(
  parameter int N_CTX = 8,
  localparam int CTX_W = (N_CTX > 1) ? $clog2(N_CTX) : 1,
  localparam int ADDR_W = CTX_W + 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              flt_valid,
  input  logic [CTX_W-1:0]  flt_ctx,
  input  logic [3:0]        flt_flags,
  input  logic [2:0]        flt_code,
  input  logic [1:0]        flt_level,
  input  logic [31:0]       flt_addr,
  input  logic [N_CTX-1:0]  flush_done,
  output logic [N_CTX-1:0]  flush_req,
  output logic              irq
);
  logic [CTX_W-1:0] sel_ctx;
  logic [3:0]       word;
  logic             ctx_ok;
  logic [DW-1:0]    slot_rd [N_CTX];
  logic [N_CTX-1:0] irq_src;
  logic [1:0]       unused_low;
  fault_t           flt;

  assign sel_ctx    = bus_addr[ADDR_W-1:6];
  assign word       = bus_addr[5:2];
  assign unused_low = bus_addr[1:0];
  assign ctx_ok     = int'(sel_ctx) < N_CTX;
  assign flt        = '{flags: flt_flags, code: flt_code, level: flt_level,
                        addr: flt_addr};

  generate
    for (genvar i = 0; i < N_CTX; i++) begin : g_ctx
      xctx_slot u_slot (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (bus_wr && ctx_ok && sel_ctx == CTX_W'(i)),
        .wr_word    (word),
        .wr_data    (bus_wdata),
        .rd_word    (word),
        .rd_data    (slot_rd[i]),
        .flt_hit    (flt_valid && flt_ctx == CTX_W'(i)),
        .flt        (flt),
        .flush_done (flush_done[i]),
        .flush_req  (flush_req[i]),
        .irq_src    (irq_src[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                   bus_rdata <= '0;
    else if (bus_rd && ctx_ok) bus_rdata <= slot_rd[sel_ctx];
    else                       bus_rdata <= '0;
  end

  xctx_irq #(.N(N_CTX)) u_irq (
    .clk (clk),
    .rst (rst),
    .src (irq_src),
    .irq (irq)
  );

  p_hole_r10: assert property (@(posedge clk) disable iff (rst)
    bus_rd && !word_mapped(word) |=> bus_rdata == '0);
endmodule

// File: tb/test_xctx_bank.sv
module test_xctx_bank;
  logic        clk = 0;
  logic        rst = 1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        flt_valid = 0;
  logic [2:0]  flt_ctx = '0;
  logic [3:0]  flt_flags = '0;
  logic [2:0]  flt_code = '0;
  logic [1:0]  flt_level = '0;
  logic [31:0] flt_addr = '0;
  logic [7:0]  flush_done = '0, flush_req;
  logic        irq;
  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xctx_bank i_xctx_bank (.*);

  // {write, addr, wdata, expected read}
  localparam int NV = 20;
  localparam logic [73:0] VEC [NV] = '{
    {1'b1, 9'h040, 32'hFFFF_FFFD, 32'h0},           // R3 ctrl mask
    {1'b0, 9'h040, 32'h0, 32'h0003_003D},
    {1'b1, 9'h088, 32'hDEAD_BEEF, 32'h0},           // R11 xlat ctrl
    {1'b0, 9'h088, 32'h0, 32'hDEAD_BEEF},
    {1'b1, 9'h08C, 32'hFFFF_FFFF, 32'h0},           // R11 bus ctrl
    {1'b0, 9'h08C, 32'h0, 32'h0000_0007},
    {1'b1, 9'h1D0, 32'h1234_5678, 32'h0},           // R2 ctx7 base
    {1'b0, 9'h1D0, 32'h0, 32'h1234_5678},
    {1'b1, 9'h1DC, 32'hA5A5_A5A5, 32'h0},           // R2
    {1'b0, 9'h1DC, 32'h0, 32'hA5A5_A5A5},
    {1'b1, 9'h0EC, 32'h0F0F_0F0F, 32'h0},           // R11 attr
    {1'b0, 9'h0EC, 32'h0, 32'h0F0F_0F0F},
    {1'b1, 9'h0C4, 32'hFFFF_FFFF, 32'h0},           // R10 hole
    {1'b0, 9'h0C4, 32'h0, 32'h0},
    {1'b0, 9'h0F4, 32'h0, 32'h0},                   // R10
    {1'b0, 9'h080, 32'h0, 32'h0},                   // R2 isolation
    {1'b0, 9'h048, 32'h0, 32'h0},                   // R2
    {1'b1, 9'h0F0, 32'hFFFF_FFFF, 32'h0},           // R10 read-only
    {1'b0, 9'h0F0, 32'h0, 32'h0},
    {1'b0, 9'h1C8, 32'h0, 32'h0}                    // R2
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic fault(input logic [2:0] c, input logic [3:0] f,
                       input logic [2:0] code, input logic [1:0] lvl,
                       input logic [31:0] a);
    @(negedge clk); flt_valid = 1; flt_ctx = c; flt_flags = f;
    flt_code = code; flt_level = lvl; flt_addr = a;
    @(negedge clk); flt_valid = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(9'h000, d); check("R1 ctrl", d, 0);
    rd(9'h148, d); check("R1 xlat", d, 0);
    rd(9'h1E0, d); check("R1 status", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 flush_req", {24'b0, flush_req}, 0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][73]) wr(VEC[k][72:64], VEC[k][63:32]);
      else begin
        rd(VEC[k][72:64], d);
        check($sformatf("R2/R3/R10/R11 vec%0d", k), d, VEC[k][31:0]);
      end
    end

    // R4 flush handshake
    wr(9'h000, 32'h3);
    check("R4 req", {31'b0, flush_req[0]}, 1);
    repeat (4) @(negedge clk);
    rd(9'h000, d); check("R4 held", d, 32'h3);
    flush_done[0] = 1; @(negedge clk); flush_done[0] = 0;
    check("R4 req drop", {31'b0, flush_req[0]}, 0);
    rd(9'h000, d); check("R4 cleared", d, 32'h1);

    // R5 flush on disabled context
    wr(9'h100, 32'h2);
    check("R5 req", {31'b0, flush_req[4]}, 0);
    rd(9'h100, d); check("R5 ctrl", d, 0);

    // R6 capture on ctx5, interrupt disabled
    fault(3'd5, 4'b0001, 3'd4, 2'd2, 32'hCAFE_1000);
    @(negedge clk);
    check("R9 masked", {31'b0, irq}, 0);
    rd(9'h160, d); check("R6 status", d, 32'h0000_2401);
    rd(9'h170, d); check("R6 addr", d, 32'hCAFE_1000);
    wr(9'h140, 32'h5);
    @(negedge clk);
    check("R9 raise", {31'b0, irq}, 1);

    // R7 second fault dropped
    fault(3'd5, 4'b1010, 3'd1, 2'd1, 32'h0000_1111);
    rd(9'h160, d); check("R7 status", d, 32'h0000_2401);
    rd(9'h170, d); check("R7 addr", d, 32'hCAFE_1000);

    // R8 clear by any write
    wr(9'h160, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R9 drop", {31'b0, irq}, 0);
    rd(9'h160, d); check("R8 status", d, 0);
    rd(9'h170, d); check("R8 addr", d, 0);

    // R6 multi-hit/abort field positions on ctx6
    fault(3'd6, 4'b1100, 3'd5, 2'd3, 32'h8000_0004);
    rd(9'h1A0, d); check("R6 flags", d, 32'h0000_3514);
    @(negedge clk);
    check("R9 ctx6 masked", {31'b0, irq}, 0);

    finish_run();
  end
endmodule